// File: doc/BRIEF.md
# Reset-Time Configuration Boot Sequencer

This block decides what a switch does between the end of a fundamental reset and the start of normal traffic. It samples a three-bit boot-mode strap and a park strap once, when the active-low reset is released. In the EEPROM boot mode it walks an image held in a serial EEPROM and turns each record into a write on the configuration register port. The image is fetched one byte at a time through a simple read-command port that feeds an external SMBus master engine. In the plain mode it skips the EEPROM and the register defaults stand.

If the park strap was high, the block stops once loading is over and stays parked with operation held off. While parked, software on the SMBus slave side can read and write configuration registers through the block. Operation starts only when software clears the park bit in the block's own control word. A single output tells the rest of the chip when normal operation may begin.

The EEPROM image starts with a record count in byte 0. Records follow back to back from byte 1. Each record holds one address byte and then four data bytes, most significant byte first.

Top module: `cfgb_boot_seq`

## Requirements
- R1: While `rst_n` is low, `op_run`, `rd_req` and `cfg_we` are 0. In plain mode without parking, `op_run` is 0 after the first rising clock edge that follows reset release and 1 after the second.
- R2: Mode value 0 selects plain boot. No EEPROM read is issued, no configuration write is made, and `op_run` rises.
- R3: Mode value 1 selects EEPROM boot. Bytes are read at consecutive addresses starting from 0, and `rd_req` and `rd_addr` stay steady until `rd_done` arrives. Each record produces exactly one `cfg_we` pulse, with the record's address byte on `cfg_waddr` and its four data bytes, MSB first, on `cfg_wdata`. Records are written in image order, and `op_run` rises afterwards.
- R4: If 1 + 5 × count exceeds the EEPROM size (2^ROM_AW bytes), only the count byte is read. No configuration write is made, the load-error status bit is set, and the sequence still completes.
- R5: A NACK on any byte read sets the load-error bit and stops reading after that byte. The record that was being read is not written. Records completed earlier stay written.
- R6: A count of 0 reads only byte 0, makes no write and sets no error.
- R7: Mode values 2 to 7 behave like mode 0 and set a mode-error status bit. Only `rst_n` clears that bit.
- R8: The straps are captured on the first rising clock edge after reset release. Later strap changes have no effect on the sequence.
- R9: If the park strap was captured high, the block parks after any loading, with `op_run` at 0. While parked, slave writes to any address other than CTRL_ADDR pass straight through to the configuration write port.
- R10: A slave write to CTRL_ADDR with bit 0 at 0 leaves the parked state, and `op_run` is 1 from the next clock edge. A write with bit 0 at 1 changes nothing.
- R11: A slave read of CTRL_ADDR returns the park bit in bit 0, mode-error in bit 1 and load-error in bit 2, with 0 in all other bits. Reads of any other address return 0.
- R12: Slave writes made before the parked or running state (during reset, sampling or loading) are dropped and produce no configuration write.
- R13: Asserting `rst_n` low again clears all status and restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low fundamental reset, asynchronous |
| mode_strap | input | 3 | Boot-mode strap |
| halt_strap | input | 1 | Park-after-boot strap |
| rd_req | output | 1 | EEPROM byte read request to the SMBus master |
| rd_addr | output | ROM_AW | EEPROM byte address |
| rd_done | input | 1 | One-cycle completion pulse from the master |
| rd_data | input | 8 | Byte returned by the master |
| rd_nack | input | 1 | Read was not acknowledged (valid with rd_done) |
| cfg_we | output | 1 | Configuration register write strobe |
| cfg_waddr | output | REG_AW | Configuration register address |
| cfg_wdata | output | DATA_W | Configuration register write data |
| sw_we | input | 1 | Slave-side register write strobe |
| sw_addr | input | REG_AW | Slave-side register address |
| sw_wdata | input | DATA_W | Slave-side write data |
| sw_rdata | output | DATA_W | Control word read data for sw_addr |
| op_run | output | 1 | Normal operation enabled |

## Verification
The bench builds the block with ROM_AW = 6, so the EEPROM holds 64 bytes. With that size a count of 12 fills 61 bytes and fits, while a count of 13 already overflows, so both sides of the size check are reached with short images. REG_AW = 8 and DATA_W = 32 stay at their defaults, so a record is five bytes. The read latency of the modelled master is varied from 0 to 3 cycles, which exercises the hold of a pending request.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_SAMPLE = 3'd1,
    ST_LOAD   = 3'd2,
    ST_HALT   = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic use_eeprom;
    logic reserved;
  } mode_dec_t;

  localparam int unsigned STAT_HALT = 0;
  localparam int unsigned STAT_MERR = 1;
  localparam int unsigned STAT_LERR = 2;

  function automatic mode_dec_t decode_mode(input logic [2:0] m);
    mode_dec_t d;
    d.use_eeprom = (m == 3'd1);
    d.reserved   = (m >= 3'd2);
    return d;
  endfunction

  function automatic logic image_fits(input int unsigned count,
                                      input int unsigned rec_bytes,
                                      input int unsigned rom_bytes);
    return (1 + count * rec_bytes) <= rom_bytes;
  endfunction

endpackage

// File: rtl/cfgb_loader.sv
module cfgb_loader
  import cfgb_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int DATA_W = 32,
  parameter int ROM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_req,
  output logic [ROM_AW-1:0] rd_addr,
  input  logic              rd_done,
  input  logic [7:0]        rd_data,
  input  logic              rd_nack,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done,
  output logic              err
);

  localparam int ADDR_BYTES = (REG_AW + 7) / 8;
  localparam int DATA_BYTES = DATA_W / 8;
  localparam int REC_BYTES  = ADDR_BYTES + DATA_BYTES;
  localparam int REC_W      = REC_BYTES * 8;
  localparam int ROM_BYTES  = 1 << ROM_AW;
  localparam int IDX_W      = $clog2(REC_BYTES);
  localparam int ALO        = REC_W - ADDR_BYTES * 8;

  typedef enum logic [1:0] {L_IDLE, L_REQ, L_GAP, L_FIN} ld_state_t;

  ld_state_t         lst;
  logic [ROM_AW-1:0] ptr;
  logic              hdr;
  logic [7:0]        remain;
  logic [IDX_W-1:0]  idx;
  logic [REC_W-1:0]  rec;
  logic [REC_W-1:0]  rec_next;
  logic              err_q;
  logic              wr_en_q;
  logic [REG_AW-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  // named events
  logic byte_ok;
  logic byte_bad;
  logic rec_last;

  assign rd_req   = (lst == L_REQ);
  assign rd_addr  = ptr;
  assign byte_ok  = rd_req && rd_done && !rd_nack;
  assign byte_bad = rd_req && rd_done && rd_nack;
  assign rec_last = (idx == IDX_W'(REC_BYTES - 1));
  assign rec_next = {rec[REC_W-9:0], rd_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lst       <= L_IDLE;
      ptr       <= '0;
      hdr       <= 1'b0;
      remain    <= '0;
      idx       <= '0;
      rec       <= '0;
      err_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      case (lst)
        L_IDLE: begin
          if (start) begin
            ptr   <= '0;
            hdr   <= 1'b1;
            idx   <= '0;
            err_q <= 1'b0;
            lst   <= L_REQ;
          end
        end
        L_REQ: begin
          if (byte_bad) begin
            err_q <= 1'b1;
            lst   <= L_FIN;
          end else if (byte_ok && hdr) begin
            hdr <= 1'b0;
            ptr <= ptr + 1'b1;
            if (rd_data == 8'd0) begin
              lst <= L_FIN;
            end else if (!image_fits({24'd0, rd_data}, REC_BYTES, ROM_BYTES)) begin
              err_q <= 1'b1;
              lst   <= L_FIN;
            end else begin
              remain <= rd_data;
              lst    <= L_GAP;
            end
          end else if (byte_ok) begin
            rec <= rec_next;
            ptr <= ptr + 1'b1;
            if (rec_last) begin
              idx       <= '0;
              wr_en_q   <= 1'b1;
              wr_addr_q <= rec_next[ALO +: REG_AW];
              wr_data_q <= rec_next[DATA_W-1:0];
              remain    <= remain - 1'b1;
              lst       <= (remain == 8'd1) ? L_FIN : L_GAP;
            end else begin
              idx <= idx + 1'b1;
              lst <= L_GAP;
            end
          end
        end
        L_GAP:   lst <= L_REQ;
        default: lst <= L_IDLE;
      endcase
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign done    = (lst == L_FIN);
  assign err     = err_q;

  // A pending request holds its address until the master answers.
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_done) |=> (rd_req && $stable(rd_addr)));

  // A NACK ends the walk at once and discards the partial record.
  assert_nack_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_bad |=> (!rd_req && !wr_en && done));

  // An error never coexists with a write of a record.
  assert_err_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && lst != L_IDLE) |-> !wr_en);

endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
  import cfgb_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int DATA_W = 32,
  parameter logic [REG_AW-1:0] CTRL_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_halt,
  input  logic              set_merr,
  input  logic              set_lerr,
  input  logic              parked,
  input  logic              sw_we,
  input  logic [REG_AW-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata,
  output logic              halt_bit,
  output logic              release_evt
);

  logic merr_q;
  logic lerr_q;
  logic hit;

  assign hit         = (sw_addr == CTRL_ADDR);
  assign release_evt = parked && sw_we && hit && !sw_wdata[STAT_HALT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_bit <= 1'b0;
      merr_q   <= 1'b0;
      lerr_q   <= 1'b0;
    end else begin
      if (set_halt)         halt_bit <= 1'b1;
      else if (release_evt) halt_bit <= 1'b0;
      if (set_merr) merr_q <= 1'b1;
      if (set_lerr) lerr_q <= 1'b1;
    end
  end

  always_comb begin
    sw_rdata = '0;
    if (hit) begin
      sw_rdata[STAT_HALT] = halt_bit;
      sw_rdata[STAT_MERR] = merr_q;
      sw_rdata[STAT_LERR] = lerr_q;
    end
  end

  assert_merr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    merr_q |=> merr_q);

  assert_lerr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lerr_q |=> lerr_q);

  assert_halt_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_bit) |-> $past(sw_we && hit && !sw_wdata[STAT_HALT]));

endmodule

// File: rtl/cfgb_boot_seq.sv
module cfgb_boot_seq
  import cfgb_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int DATA_W = 32,
  parameter int ROM_AW = 8,
  parameter logic [REG_AW-1:0] CTRL_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_strap,
  input  logic              halt_strap,
  output logic              rd_req,
  output logic [ROM_AW-1:0] rd_addr,
  input  logic              rd_done,
  input  logic [7:0]        rd_data,
  input  logic              rd_nack,
  output logic              cfg_we,
  output logic [REG_AW-1:0] cfg_waddr,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic              sw_we,
  input  logic [REG_AW-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata,
  output logic              op_run
);

  seq_state_t state;
  seq_state_t state_nx;
  logic [2:0] mode_q;
  logic       halt_q;
  mode_dec_t  dec;

  // named internal events
  logic load_start;
  logic load_end;
  logic sw_live;
  logic sw_pass;
  logic release_evt;
  logic halt_bit;
  logic ld_we;
  logic ld_done;
  logic ld_err;
  logic [REG_AW-1:0] ld_waddr;
  logic [DATA_W-1:0] ld_wdata;

  assign dec        = decode_mode(mode_q);
  assign load_start = (state == ST_SAMPLE) && dec.use_eeprom;
  assign load_end   = (state == ST_LOAD) && ld_done;
  assign sw_live    = (state == ST_HALT) || (state == ST_RUN);
  assign sw_pass    = sw_live && sw_we && (sw_addr != CTRL_ADDR);

  always_comb begin
    state_nx = state;
    case (state)
      ST_RESET:  state_nx = ST_SAMPLE;
      ST_SAMPLE: state_nx = dec.use_eeprom ? ST_LOAD : (halt_q ? ST_HALT : ST_RUN);
      ST_LOAD:   if (ld_done) state_nx = halt_q ? ST_HALT : ST_RUN;
      ST_HALT:   if (release_evt) state_nx = ST_RUN;
      ST_RUN:    state_nx = ST_RUN;
      default:   state_nx = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RESET;
      mode_q <= '0;
      halt_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_RESET) begin
        mode_q <= mode_strap;
        halt_q <= halt_strap;
      end
    end
  end

  cfgb_loader #(.REG_AW(REG_AW), .DATA_W(DATA_W), .ROM_AW(ROM_AW)) u_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (load_start),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_done (rd_done),
    .rd_data (rd_data),
    .rd_nack (rd_nack),
    .wr_en   (ld_we),
    .wr_addr (ld_waddr),
    .wr_data (ld_wdata),
    .done    (ld_done),
    .err     (ld_err)
  );

  cfgb_ctrl #(.REG_AW(REG_AW), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_halt    ((state == ST_SAMPLE) && halt_q),
    .set_merr    ((state == ST_SAMPLE) && dec.reserved),
    .set_lerr    (load_end && ld_err),
    .parked      (state == ST_HALT),
    .sw_we       (sw_we),
    .sw_addr     (sw_addr),
    .sw_wdata    (sw_wdata),
    .sw_rdata    (sw_rdata),
    .halt_bit    (halt_bit),
    .release_evt (release_evt)
  );

  assign cfg_we    = ld_we | sw_pass;
  assign cfg_waddr = ld_we ? ld_waddr : sw_addr;
  assign cfg_wdata = ld_we ? ld_wdata : sw_wdata;
  assign op_run    = (state == ST_RUN);

  // Running implies the EEPROM side is quiet.
  assert_run_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_run |-> !rd_req);

  // Plain boot never touches the EEPROM.
  assert_plain_noread_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RESET && !dec.use_eeprom) |-> !rd_req);

  // Loader writes appear only while loading.
  assert_ld_in_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> (state == ST_LOAD));

  // Before parking or running, only the loader may write.
  assert_sw_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_live && !ld_we) |-> !cfg_we);

  // Parked means not running and the park bit is held.
  assert_park_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> (halt_bit && !op_run));

  // Straps are frozen once sampled.
  assert_strap_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RESET) |=> $stable(mode_q));

endmodule

// File: tb/sim_cfgb_boot_seq.sv
module sim_cfgb_boot_seq;

  localparam int CLK_PERIOD = 10;
  localparam int REG_AW = 8;
  localparam int DATA_W = 32;
  localparam int ROM_AW = 6;
  localparam int ROM_N  = 1 << ROM_AW;
  localparam logic [REG_AW-1:0] CTRL = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_strap = '0;
  logic halt_strap = 1'b0;
  logic rd_req;
  logic [ROM_AW-1:0] rd_addr;
  logic rd_done = 1'b0;
  logic [7:0] rd_data = '0;
  logic rd_nack = 1'b0;
  logic cfg_we;
  logic [REG_AW-1:0] cfg_waddr;
  logic [DATA_W-1:0] cfg_wdata;
  logic sw_we = 1'b0;
  logic [REG_AW-1:0] sw_addr = '0;
  logic [DATA_W-1:0] sw_wdata = '0;
  logic [DATA_W-1:0] sw_rdata;
  logic op_run;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgb_boot_seq #(.REG_AW(REG_AW), .DATA_W(DATA_W), .ROM_AW(ROM_AW), .CTRL_ADDR(CTRL)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .halt_strap(halt_strap),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
    .rd_nack(rd_nack), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .op_run(op_run)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] rom [ROM_N];
  int nack_at = -1;
  int lat = 1;
  int nrd = 0;
  logic [REG_AW-1:0] obs_a [64];
  logic [DATA_W-1:0] obs_d [64];
  int nw = 0;
  logic [REG_AW-1:0] ex_a [64];
  logic [DATA_W-1:0] ex_d [64];
  int ex_n;
  int ex_rd;
  bit ex_err;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // EEPROM side of the SMBus master
  initial forever begin
    @(negedge clk);
    if (rd_req && rst_n) begin
      automatic logic [ROM_AW-1:0] a = rd_addr;
      nrd++;
      repeat (lat) @(negedge clk);
      rd_data = rom[a];
      rd_nack = (int'(a) == nack_at);
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
      rd_nack = 1'b0;
    end
  end

  // configuration write monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (cfg_we && nw < 64) begin
      obs_a[nw] = cfg_waddr;
      obs_d[nw] = cfg_wdata;
      nw++;
    end
  end

  task automatic build_image(input int n);
    for (int i = 0; i < ROM_N; i++) rom[i] = 8'($urandom);
    rom[0] = 8'(n);
  endtask

  function automatic void compute_expect();
    int n;
    ex_n = 0; ex_err = 0; ex_rd = 1;
    if (nack_at == 0) begin ex_err = 1; return; end
    n = int'(rom[0]);
    if (n == 0) return;
    if (1 + 5 * n > ROM_N) begin ex_err = 1; return; end
    for (int r = 0; r < n; r++) begin
      for (int b = 0; b < 5; b++) begin
        if (1 + 5 * r + b == nack_at) begin
          ex_err = 1; ex_rd = nack_at + 1; return;
        end
      end
      ex_a[ex_n] = rom[1 + 5 * r];
      ex_d[ex_n] = {rom[2 + 5 * r], rom[3 + 5 * r], rom[4 + 5 * r], rom[5 + 5 * r]};
      ex_n++;
    end
    ex_rd = 1 + 5 * n;
  endfunction

  task automatic do_reset(input logic [2:0] m, input logic h);
    @(negedge clk);
    mode_strap = m;
    halt_strap = h;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    nw = 0;
    nrd = 0;
    rst_n = 1'b1;
  endtask

  task automatic settle();
    repeat (600) @(negedge clk);
  endtask

  task automatic sw_write(input logic [REG_AW-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    sw_addr = a; sw_wdata = d; sw_we = 1'b1;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_read(input logic [REG_AW-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    sw_addr = a;
    #1;
    d = sw_rdata;
  endtask

  task automatic check_load(input string req);
    logic [DATA_W-1:0] st;
    compute_expect();
    chk(nw == ex_n, {req, " write count"}, nw, ex_n);
    for (int i = 0; i < ex_n && i < nw; i++) begin
      chk(obs_a[i] == ex_a[i], {req, " write addr"}, obs_a[i], ex_a[i]);
      chk(obs_d[i] == ex_d[i], {req, " write data"}, obs_d[i], ex_d[i]);
    end
    chk(nrd == ex_rd, {req, " read count"}, nrd, ex_rd);
    sw_read(CTRL, st);
    chk(st[2] == ex_err, {req, " load-error bit R11"}, st[2], ex_err);
    chk(op_run == 1'b1, {req, " op_run"}, op_run, 1);
  endtask

  initial begin
    logic [DATA_W-1:0] st;
    int seed;
    seed = $urandom(32'd20240611);
    build_image(0);

    // R1: reset state and exact start-up timing
    @(negedge clk);
    #1;
    chk(op_run == 0 && rd_req == 0 && cfg_we == 0, "R1 outputs in reset", {op_run, rd_req, cfg_we}, 0);
    do_reset(3'd0, 1'b0);
    @(negedge clk);
    chk(op_run == 0, "R1 op_run after first edge", op_run, 0);
    @(negedge clk);
    chk(op_run == 1, "R1 op_run after second edge", op_run, 1);

    // R2: plain mode
    settle();
    chk(nrd == 0, "R2 no EEPROM reads", nrd, 0);
    chk(nw == 0, "R2 no config writes", nw, 0);
    sw_read(CTRL, st);
    chk(st == 0, "R2 R11 status clear", st, 0);
    sw_read(8'h10, st);
    chk(st == 0, "R11 other address reads 0", st, 0);

    // R3: random images, random latency
    for (int it = 0; it < 8; it++) begin
      build_image(1 + int'($urandom_range(11)));
      lat = int'($urandom_range(3));
      nack_at = -1;
      do_reset(3'd1, 1'b0);
      settle();
      check_load("R3");
    end
    lat = 1;

    // R4: exact fit (12 records, 61 bytes) and overflow (13, 255)
    build_image(12); nack_at = -1;
    do_reset(3'd1, 1'b0); settle(); check_load("R4 exact fit");
    build_image(13);
    do_reset(3'd1, 1'b0); settle(); check_load("R4 overflow 13");
    build_image(255);
    do_reset(3'd1, 1'b0); settle(); check_load("R4 overflow 255");

    // R5: NACK inside the third record, then on the count byte
    build_image(5); nack_at = 1 + 5 * 2 + int'($urandom_range(4));
    do_reset(3'd1, 1'b0); settle(); check_load("R5 nack mid record");
    nack_at = 0;
    do_reset(3'd1, 1'b0); settle(); check_load("R5 nack on count");
    nack_at = -1;

    // R6: empty image
    build_image(0);
    do_reset(3'd1, 1'b0); settle(); check_load("R6 empty");

    // R7: reserved modes
    for (int m = 2; m < 8; m++) begin
      do_reset(3'(m), 1'b0);
      settle();
      sw_read(CTRL, st);
      chk(st == 32'h2, "R7 mode-error bit only", st, 2);
      chk(nrd == 0 && op_run == 1, "R7 acts as plain", {nrd[7:0], op_run}, 1);
    end

    // R8: strap changes after capture are ignored
    build_image(3);
    do_reset(3'd1, 1'b0);
    @(negedge clk);
    mode_strap = 3'd0; halt_strap = 1'b1;
    settle();
    check_load("R8 eeprom kept");
    do_reset(3'd0, 1'b0);
    @(negedge clk);
    mode_strap = 3'd1;
    settle();
    chk(nrd == 0 && op_run == 1, "R8 plain kept", {nrd[7:0], op_run}, 1);

    // R9 R10 R12: park after load, with a dropped write during loading
    build_image(4); lat = 3;
    do_reset(3'd1, 1'b1);
    repeat (4) @(negedge clk);
    sw_write(8'h33, 32'hDEADBEEF);
    settle();
    compute_expect();
    chk(nw == ex_n, "R12 write during load dropped", nw, ex_n);
    chk(op_run == 0, "R9 parked op_run", op_run, 0);
    sw_read(CTRL, st);
    chk(st == 32'h1, "R9 R11 park bit", st, 1);
    nw = 0;
    sw_write(8'h20, 32'h12345678);
    chk(nw == 1 && obs_a[0] == 8'h20 && obs_d[0] == 32'h12345678, "R9 pass-through write",
        {obs_a[0], obs_d[0]}, {8'h20, 32'h12345678});
    sw_write(CTRL, 32'h1);
    repeat (3) @(negedge clk);
    chk(op_run == 0, "R10 write of 1 keeps park", op_run, 0);
    sw_write(CTRL, 32'h0);
    chk(op_run == 1, "R10 release to run", op_run, 1);
    sw_read(CTRL, st);
    chk(st == 0, "R10 park bit cleared", st, 0);
    lat = 1;

    // R7 sticky across release, then R13 reset clears it
    do_reset(3'd5, 1'b1);
    settle();
    sw_write(CTRL, 32'h0);
    sw_read(CTRL, st);
    chk(st == 32'h2 && op_run == 1, "R7 sticky after release", st, 2);
    build_image(20);
    do_reset(3'd1, 1'b0);
    settle();
    do_reset(3'd0, 1'b0);
    settle();
    sw_read(CTRL, st);
    chk(st == 0 && op_run == 1, "R13 reset clears status", st, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule